// File: doc/BRIEF.md
# Per-Bit Port/Segment Multiplexed I/O Port

This block is an 8-bit general-purpose I/O port in which every pin can be handed, one bit at a time, either to the port or to an LCD segment driver. A CPU reaches it over a plain register bus that has an address, a write strobe, write data, a read strobe and read data. Three registers sit on that bus: an output latch, a mode register that chooses port or segment per bit, and a read-only view of the synchronized pin levels.

When a bit is in port mode, its latch value goes to the pin. A latch value of 0 is driven actively. A latch value of 1 is not driven, so the pin floats to a weak high and an external device can drive it. A bit set this way works as an input. When a bit is in segment mode, the segment data for that bit is driven onto the pin. A STOP condition or a deasserted global enable removes every pin drive.

Software reads the latch and the pins at separate addresses. It can therefore tell what it wrote apart from what the pad actually shows. Pin levels pass through a two-stage synchronizer before they can be read.

Top module: `mux_port`

## Requirements
- R1: After reset the output latch reads 0xFF, the mode register reads 0x00, every pin output enable is 0 and every pin output is 1.
- R2: A write strobe at address 0x05 loads the write data into the output latch on that clock edge. A read at 0x05 then returns the new value.
- R3: A write strobe at address 0x2A loads the write data into the mode register on that clock edge. A read at 0x2A returns its contents.
- R4: A read at 0x0B returns the pin input levels as they were two rising clock edges earlier. A write to 0x0B changes neither the latch nor the mode register.
- R5: With a mode bit of 0, the pin output for that bit equals the latch bit. The output enable is 1 when the latch bit is 0 and 0 when the latch bit is 1, as long as the outputs are not gated off.
- R6: With a mode bit of 1, the pin output for that bit equals the segment data bit and the output enable is 1, as long as the outputs are not gated off.
- R7: When stopMode is 1 or globalOe is 0, every bit of pinOe is 0 in every mode.
- R8: A read at 0x05 returns the latch contents even when the pin levels differ from them.
- R9: A read at any address other than 0x05, 0x0B or 0x2A returns 0. A write to such an address changes neither the latch nor the mode register.
- R10: While busRe is 0, busRdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | 8 | Read data (combinational) |
| pinIn | input | 8 | Levels sampled at the pads |
| pinOut | output | 8 | Value driven onto each pad |
| pinOe | output | 8 | Per-pad drive enable |
| segData | input | 8 | Per-bit LCD segment level |
| stopMode | input | 1 | STOP condition; removes all pin drive |
| globalOe | input | 1 | Global output enable; 0 removes all pin drive |

## Verification
The assertions check several properties on every cycle. They check that the latch and mode register take the written value at the next edge. They check that writes to the pin address or to unmapped addresses leave both registers unchanged. They also check that gating forces every enable low, that a port-mode pin follows the latch, and that idle or unmapped reads return zero. Other behaviour is shown only by the bench's sweeps. These cover readback of every latch and mode value, and the two-edge delay of pin sampling, with bits in segment mode masked. They also cover the full combination of mode, latch, segment data and gating, and the fact that latch reads ignore the pin levels.

// File: rtl/mux_port_pkg.sv
package mux_port_pkg;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_LATCH = 2'd1,
    RD_MODE  = 2'd2,
    RD_PINS  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   wrLatch;
    logic   wrMode;
    rdSrc_e rdSrc;
  } strobe_t;

endpackage

// File: rtl/mux_port_ctrl.sv
module mux_port_ctrl
  import mux_port_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] ADDR_LATCH = 8'h05,
  parameter logic [ADDR_W-1:0] ADDR_PINS  = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_MODE  = 8'h2A
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output strobe_t           strobe
);

  logic hitLatch, hitMode, hitPins;

  always_comb begin
    hitLatch = (busAddr == ADDR_LATCH);
    hitMode  = (busAddr == ADDR_MODE);
    hitPins  = (busAddr == ADDR_PINS);
  end

  always_comb begin
    strobe.wrLatch = busWe & hitLatch;
    strobe.wrMode  = busWe & hitMode;
    if (!busRe)        strobe.rdSrc = RD_NONE;
    else if (hitLatch) strobe.rdSrc = RD_LATCH;
    else if (hitMode)  strobe.rdSrc = RD_MODE;
    else if (hitPins)  strobe.rdSrc = RD_PINS;
    else               strobe.rdSrc = RD_NONE;
  end

endmodule

// File: rtl/mux_port_dp.sv
module mux_port_dp
  import mux_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strobe,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  input  logic [WIDTH-1:0] segData,
  input  logic             stopMode,
  input  logic             globalOe,
  output logic [WIDTH-1:0] latchQ,
  output logic [WIDTH-1:0] modeQ
);

  localparam logic [WIDTH-1:0] LATCH_INIT = '1;
  localparam logic [WIDTH-1:0] MODE_INIT  = '0;

  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinSampled;
  logic             driveOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchQ <= LATCH_INIT;
      modeQ  <= MODE_INIT;
    end else begin
      if (strobe.wrLatch) latchQ <= busWdata;
      if (strobe.wrMode)  modeQ  <= busWdata;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinSampled = syncQ[SYNC_STAGES-1];
  assign driveOk    = globalOe & ~stopMode;

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_comb begin
        if (modeQ[b]) begin
          pinOut[b] = segData[b];
          pinOe[b]  = driveOk;
        end else begin
          pinOut[b] = latchQ[b];
          pinOe[b]  = driveOk & ~latchQ[b];
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSrc)
      RD_LATCH: busRdata = latchQ;
      RD_MODE:  busRdata = modeQ;
      RD_PINS:  busRdata = pinSampled;
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/mux_port.sv
module mux_port
  import mux_port_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                WIDTH       = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_LATCH  = 8'h05,
  parameter logic [ADDR_W-1:0] ADDR_PINS   = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_MODE   = 8'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [WIDTH-1:0]  busWdata,
  input  logic              busRe,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  input  logic [WIDTH-1:0]  segData,
  input  logic              stopMode,
  input  logic              globalOe
);

  strobe_t          strobe;
  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] modeQ;

  mux_port_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_LATCH(ADDR_LATCH),
    .ADDR_PINS(ADDR_PINS), .ADDR_MODE(ADDR_MODE)
  ) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .strobe(strobe)
  );

  mux_port_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .segData(segData), .stopMode(stopMode), .globalOe(globalOe),
    .latchQ(latchQ), .modeQ(modeQ)
  );

endmodule

// File: rtl/mux_port_chk.sv
module mux_port_chk #(
  parameter int                ADDR_W     = 8,
  parameter int                WIDTH      = 8,
  parameter logic [ADDR_W-1:0] ADDR_LATCH = 8'h05,
  parameter logic [ADDR_W-1:0] ADDR_PINS  = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_MODE  = 8'h2A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [WIDTH-1:0]  busWdata,
  input logic              busRe,
  input logic [WIDTH-1:0]  busRdata,
  input logic [WIDTH-1:0]  pinOut,
  input logic [WIDTH-1:0]  pinOe,
  input logic              stopMode,
  input logic              globalOe,
  input logic [WIDTH-1:0]  latchQ,
  input logic [WIDTH-1:0]  modeQ
);

  logic mapped;
  assign mapped = (busAddr == ADDR_LATCH) || (busAddr == ADDR_PINS) ||
                  (busAddr == ADDR_MODE);

  a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_LATCH) |=> latchQ == $past(busWdata));

  a_r3_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_MODE) |=> modeQ == $past(busWdata));

  a_r4_pins_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_PINS) |=> ($stable(latchQ) && $stable(modeQ)));

  a_r9_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && !mapped) |=> ($stable(latchQ) && $stable(modeQ)));

  a_r9_unmapped_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (busRe && !mapped) |-> busRdata == '0);

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (stopMode || !globalOe) |-> pinOe == '0);

  a_r5_port_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ((pinOut & ~modeQ) == (latchQ & ~modeQ)));

  a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !busRe |-> busRdata == '0);

endmodule

bind mux_port mux_port_chk #(
  .ADDR_W(ADDR_W), .WIDTH(WIDTH), .ADDR_LATCH(ADDR_LATCH),
  .ADDR_PINS(ADDR_PINS), .ADDR_MODE(ADDR_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
  .pinOut(pinOut), .pinOe(pinOe), .stopMode(stopMode),
  .globalOe(globalOe), .latchQ(latchQ), .modeQ(modeQ)
);

// File: tb/sim_mux_port.sv
`timescale 1ns/1ps
module sim_mux_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic       busRe = 1'b0;
  logic [7:0] busRdata;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;
  logic [7:0] segData = '0;
  logic       stopMode = 1'b0;
  logic       globalOe = 1'b1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  mux_port u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .segData(segData),
    .stopMode(stopMode), .globalOe(globalOe)
  );

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    busRe = 1'b0;
    #1;
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] expOut, expOe;
    logic       gateOn;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(8'h05, rd); check("R1 latch", rd, 8'hFF);
    busRead(8'h2A, rd); check("R1 mode", rd, 8'h00);
    check("R1 oe", pinOe, 8'h00);
    check("R1 out", pinOut, 8'hFF);

    // R10 idle read
    busAddr = 8'h05; #1 check("R10 idle", busRdata, 8'h00);

    // R2/R8 latch sweep with pins held at the complement
    for (int v = 0; v < 256; v++) begin
      pinIn = ~8'(v);
      busWrite(8'h05, 8'(v));
      busRead(8'h05, rd);
      check("R2 latch rw", rd, 8'(v));
      check("R8 latch not pins", rd, ~pinIn);
    end

    // R3 mode sweep
    for (int v = 0; v < 256; v++) begin
      busWrite(8'h2A, 8'(v));
      busRead(8'h2A, rd);
      check("R3 mode rw", rd, 8'(v));
    end

    // R4 pin sampling: two edges of delay, segment-mode bits masked
    busWrite(8'h2A, 8'h0F);
    for (int v = 0; v < 256; v += 3) begin
      pinIn = 8'(v);
      @(negedge clk);
      busRead(8'h0B, rd);
      if (v >= 3) check("R4 one-edge old", rd & 8'hF0, 8'(v - 3) & 8'hF0);
      @(negedge clk);
      busRead(8'h0B, rd);
      check("R4 pins", rd & 8'hF0, 8'(v) & 8'hF0);
    end

    // R4 write to pin address ignored
    busWrite(8'h05, 8'h3C);
    busWrite(8'h2A, 8'h81);
    busWrite(8'h0B, 8'hE7);
    busRead(8'h05, rd); check("R4 wr pins latch", rd, 8'h3C);
    busRead(8'h2A, rd); check("R4 wr pins mode", rd, 8'h81);

    // R9 unmapped write ignored and read zero
    busWrite(8'h10, 8'h55);
    busWrite(8'h2B, 8'h66);
    busRead(8'h05, rd); check("R9 wr latch", rd, 8'h3C);
    busRead(8'h2A, rd); check("R9 wr mode", rd, 8'h81);
    busRead(8'h10, rd); check("R9 rd", rd, 8'h00);
    busRead(8'hFF, rd); check("R9 rd", rd, 8'h00);

    // R5/R6/R7 pin mux sweep
    for (int m = 0; m < 16; m++) begin
      busWrite(8'h2A, 8'(m * 17));
      for (int l = 0; l < 16; l++) begin
        busWrite(8'h05, 8'((l * 37) ^ 8'hA5));
        for (int s = 0; s < 4; s++) begin
          for (int g = 0; g < 4; g++) begin
            segData  = 8'(s * 85) ^ 8'h0F;
            stopMode = g[0];
            globalOe = g[1];
            #1;
            gateOn = globalOe & ~stopMode;
            expOut = (8'(m * 17) & segData) |
                     (~8'(m * 17) & 8'((l * 37) ^ 8'hA5));
            expOe  = gateOn ? (8'(m * 17) | ~8'((l * 37) ^ 8'hA5)) : 8'h00;
            check(m == 0 ? "R5 out" : "R6 out", pinOut, expOut);
            check(gateOn ? (m == 0 ? "R5 oe" : "R6 oe") : "R7 oe",
                  pinOe, expOe);
          end
        end
      end
    end
    stopMode = 1'b0; globalOe = 1'b1;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule